// File: doc/BRIEF.md
# Oscillator Startup and Main Clock Source Controller

This block sits beside a crystal oscillator and the root clock multiplexer. Software sets a crystal range code and a startup delay code through a small register port, then turns the oscillator on. A counter running on a slow reference clock waits out the coded number of reference cycles. It then reports the oscillator as ready through a status word, after a two-flop synchroniser into the bus clock.

Software also asks for a main clock source: slow clock, oscillator 0 or PLL 0. The block drives the effective source code, which the external glitch-free multiplexer uses, and it can be read back. A request for oscillator 0 is held off until the oscillator is ready. If the oscillator loses readiness while it is in use, the block falls back to the slow clock. Turning the oscillator off drops readiness at once, and turning it on again starts the full wait from zero.

Top module: `osc_clk_ctrl`

## Requirements
- R1: After reset every register reads zero, `clk_sel_o` is 0 (slow clock), both oscillator enables are low and the ready flag is clear.
- R2: Word address 0 (main control) holds the requested source in bits 1:0, the oscillator 0 enable in bit 2 and the oscillator 1 enable in bit 3. Word address 1 (oscillator control) holds the crystal mode in bits 2:0 and the startup code in bits 10:8. Both read back as written, with all other bits zero.
- R3: Startup codes 0 to 6 map to waits of 0, 64, 128, 2048, 4096, 8192 and 16384 slow cycles, each shifted right by `DELAY_SHIFT`. Ready never shows before that many slow cycles after the enable write, and it shows within five more slow cycles.
- R4: Startup code 7 uses the same wait as code 6.
- R5: Word address 2 (status) shows oscillator 0 readiness in bit 7, with all other bits zero.
- R6: Clearing the oscillator 0 enable clears the ready flag in the next bus cycle. A later enable restarts the full wait, even if it is written within a few bus cycles of the disable.
- R7: Writes to oscillator control are ignored while oscillator 0 is enabled.
- R8: A request for source 1 (oscillator 0) changes the effective source only once ready is set. Until then the previous source stays. The effective source is read at word address 3, bits 1:0, and on `clk_sel_o`.
- R9: A request for source 0 (slow) or 2 (PLL 0) becomes effective on the second bus clock edge after the write.
- R10: Source code 3 is reserved. Requesting it leaves the effective source unchanged, and `clk_sel_o` never shows 3.
- R11: If the effective source is oscillator 0 and ready drops, the effective source goes to 0 (slow) on the next edge.
- R12: `osc_mode_o`, `osc0_en_o` and `osc1_en_o` follow their register fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| slow_clk_i | input | 1 | Slow reference clock for the startup counter |
| reg_addr_i | input | ADDR_W | Word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data (combinational) |
| clk_sel_o | output | 2 | Effective main clock source code |
| osc0_en_o | output | 1 | Oscillator 0 enable |
| osc1_en_o | output | 1 | Oscillator 1 enable |
| osc_mode_o | output | 3 | Crystal mode for oscillator 0 |

## Verification
The bench builds the block with `DELAY_SHIFT` = 4 and a slow clock eight times slower than the bus clock. This shrinks the largest wait to 1024 reference cycles, so both the reserved startup code and the restart after a quick disable and re-enable can be measured exactly inside a short run. The default shift of 0 keeps the full-length waits. The tightened table still keeps every code distinct, so a wrong table entry moves ready out of its window.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_OSC0 = 2'd1,
    SRC_PLL0 = 2'd2,
    SRC_RSVD = 2'd3
  } clk_src_e;

  localparam int unsigned ADDR_MAIN = 0;
  localparam int unsigned ADDR_OSC  = 1;
  localparam int unsigned ADDR_STAT = 2;
  localparam int unsigned ADDR_EFF  = 3;

  localparam int unsigned STAT_RDY_BIT = 7;
  localparam int unsigned STUP_LSB     = 8;
  localparam int unsigned MAX_WAIT     = 16384;

  // slow-clock cycles per startup code; code 7 aliases code 6
  function automatic logic [31:0] startup_cycles(input logic [2:0] code);
    logic [31:0] v;
    case (code)
      3'd0:    v = 32'd0;
      3'd1:    v = 32'd64;
      3'd2:    v = 32'd128;
      3'd7:    v = 32'(MAX_WAIT);
      default: v = 32'd2048 << (code - 3'd3);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned DELAY_SHIFT = 0
) (
  input  logic       slow_clk_i,
  input  logic       rst_ni,
  input  logic       en_i,      // bus domain, synchronised here
  input  logic [2:0] code_i,    // quasi-static while enabled
  output logic       ready_o,
  output logic       echo_o     // enable as seen by this domain
);
  localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);

  logic             en_s;
  logic [CNT_W-1:0] cnt_q, target;
  logic             rdy_q, echo_q;

  sync_2ff #(.WIDTH(1), .STAGES(2)) u_en_sync (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_s)
  );

  assign target = CNT_W'(startup_cycles(code_i) >> DELAY_SHIFT);

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rdy_q  <= 1'b0;
      echo_q <= 1'b0;
    end else begin
      echo_q <= en_s;
      if (!en_s) begin
        cnt_q <= '0;
        rdy_q <= 1'b0;
      end else if (!rdy_q) begin
        if (cnt_q == target) rdy_q <= 1'b1;
        else                 cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o = rdy_q;
  assign echo_o  = echo_q;
endmodule

// File: rtl/clk_src_sel.sv
module clk_src_sel
  import osc_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_src_e req_i,
  input  logic     osc0_ready_i,
  output clk_src_e sel_o
);
  clk_src_e sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    case (req_i)
      SRC_SLOW, SRC_PLL0: sel_d = req_i;
      SRC_OSC0:           if (osc0_ready_i) sel_d = SRC_OSC0;
      default:            sel_d = sel_q;
    endcase
    // never remain on an oscillator that is not ready
    if (!osc0_ready_i && sel_d == SRC_OSC0) sel_d = SRC_SLOW;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SRC_SLOW;
    else         sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/osc_clk_ctrl.sv
module osc_clk_ctrl
  import osc_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DELAY_SHIFT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [1:0]        clk_sel_o,
  output logic              osc0_en_o,
  output logic              osc1_en_o,
  output logic [2:0]        osc_mode_o
);
  localparam int unsigned STUP_MSB = STUP_LSB + 2;

  clk_src_e   req_sel_q, eff_sel;
  logic       en0_q, en1_q, armed_q;
  logic [2:0] mode_q, stup_q;
  logic       rdy_slow, echo_slow, rdy_s, echo_s, osc0_rdy;
  logic       wr_main, wr_osc;

  assign wr_main = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_MAIN));
  assign wr_osc  = reg_we_i && (reg_addr_i == ADDR_W'(ADDR_OSC)) && !en0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sel_q <= SRC_SLOW;
      en0_q     <= 1'b0;
      en1_q     <= 1'b0;
      mode_q    <= '0;
      stup_q    <= '0;
    end else begin
      if (wr_main) begin
        req_sel_q <= clk_src_e'(reg_wdata_i[1:0]);
        en0_q     <= reg_wdata_i[2];
        en1_q     <= reg_wdata_i[3];
      end
      if (wr_osc) begin
        mode_q <= reg_wdata_i[2:0];
        stup_q <= reg_wdata_i[STUP_MSB:STUP_LSB];
      end
    end
  end

  // hold the slow side disabled until it has acknowledged a disable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               armed_q <= 1'b1;
    else if (wr_main && en0_q && !reg_wdata_i[2]) armed_q <= 1'b0;
    else if (!echo_s)                          armed_q <= 1'b1;
  end

  osc_startup_timer #(.DELAY_SHIFT(DELAY_SHIFT)) u_timer (
    .slow_clk_i(slow_clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en0_q & armed_q),
    .code_i    (stup_q),
    .ready_o   (rdy_slow),
    .echo_o    (echo_slow)
  );

  sync_2ff #(.WIDTH(2), .STAGES(2)) u_back_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rdy_slow, echo_slow}),
    .q_o   ({rdy_s, echo_s})
  );

  assign osc0_rdy = en0_q & armed_q & rdy_s;

  clk_src_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_sel_q),
    .osc0_ready_i(osc0_rdy),
    .sel_o       (eff_sel)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(ADDR_MAIN): reg_rdata_o[3:0] = {en1_q, en0_q, req_sel_q};
      ADDR_W'(ADDR_OSC): begin
        reg_rdata_o[2:0]               = mode_q;
        reg_rdata_o[STUP_MSB:STUP_LSB] = stup_q;
      end
      ADDR_W'(ADDR_STAT): reg_rdata_o[STAT_RDY_BIT] = osc0_rdy;
      default:            reg_rdata_o[1:0] = eff_sel;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[DATA_W-1:STUP_MSB+1], reg_wdata_i[STUP_LSB-1:4]};

  assign clk_sel_o  = eff_sel;
  assign osc0_en_o  = en0_q;
  assign osc1_en_o  = en1_q;
  assign osc_mode_o = mode_q;
endmodule

// File: rtl/osc_clk_ctrl_chk.sv
module osc_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] req_sel,
  input logic       osc0_rdy,
  input logic [1:0] clk_sel_o,
  input logic       osc0_en_o,
  input logic [2:0] osc_mode_o
);
  // R10
  sel_never_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o != 2'd3);

  // R8
  osc0_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc0_rdy |=> clk_sel_o != 2'd1);

  // R9
  sel_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_sel_o) |-> (clk_sel_o == $past(req_sel) || clk_sel_o == 2'd0));

  // R6
  rdy_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc0_rdy) |-> $past(osc0_en_o));

  // R7
  mode_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc0_en_o && $past(osc0_en_o)) |-> $stable(osc_mode_o));
endmodule

bind osc_clk_ctrl osc_clk_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_sel   (req_sel_q),
  .osc0_rdy  (osc0_rdy),
  .clk_sel_o (clk_sel_o),
  .osc0_en_o (osc0_en_o),
  .osc_mode_o(osc_mode_o)
);

// File: tb/osc_clk_ctrl_test.sv
module osc_clk_ctrl_test;
  localparam int unsigned SHIFT = 4;

  logic        clk = 0, slow_clk = 0, rst_n = 0;
  logic [1:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  clk_sel;
  logic        en0, en1;
  logic [2:0]  mode;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;
  always #20  slow_clk = ~slow_clk;

  osc_clk_ctrl #(.ADDR_W(2), .DATA_W(32), .DELAY_SHIFT(SHIFT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow_clk),
    .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .clk_sel_o(clk_sel), .osc0_en_o(en0), .osc1_en_o(en1), .osc_mode_o(mode)
  );

  function automatic int exp_wait(input int code);
    int v;
    case (code)
      0: v = 0; 1: v = 64; 2: v = 128; 3: v = 2048;
      4: v = 4096; 5: v = 8192; default: v = 16384;
    endcase
    return v >> SHIFT;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 2'(a); wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); addr = 2'(a); #1 d = rdata;
  endtask

  task automatic slow_wait(input int n);
    repeat (n) @(posedge slow_clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin rd(a, d); chk("R1 reg", d, 0); end
    chk("R1 clk_sel", {30'd0, clk_sel}, 0);
    chk("R1 enables", {30'd0, en1, en0}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(1, 32'hFFFF_F8F5);
    rd(1, d); chk("R2 osc ctrl", d, 32'h0000_0005);
    chk("R12 mode out", {29'd0, mode}, 5);
    wr(0, 32'hFFFF_FFF8);
    rd(0, d); chk("R2 main ctrl", d, 32'h8);
    chk("R12 osc1 en", {31'd0, en1}, 1);
    wr(0, 0);
  endtask

  task automatic t_delay(input int code, input string req);
    logic [31:0] d;
    int n = exp_wait(code);
    wr(1, (code << 8) | 6);
    wr(0, 32'h4);
    chk("R12 osc0 en", {31'd0, en0}, 1);
    slow_wait(n); rd(2, d); chk({req, " early"}, d, 0);
    slow_wait(5); rd(2, d); chk({req, " ready"}, d, 32'h80);
    wr(0, 0);
    slow_wait(12);
  endtask

  task automatic t_restart;
    logic [31:0] d;
    int n = exp_wait(3);
    wr(1, 3 << 8);
    wr(0, 32'h4);
    slow_wait(n + 5); rd(2, d); chk("R5 status", d, 32'h80);
    wr(0, 0);
    rd(2, d); chk("R6 clear", d, 0);
    wr(0, 32'h4);
    slow_wait(n); rd(2, d); chk("R6 restart early", d, 0);
    slow_wait(10); rd(2, d); chk("R6 restart ready", d, 32'h80);
    wr(1, (1 << 8) | 7);
    rd(1, d); chk("R7 locked", d, 3 << 8);
    chk("R7 mode out", {29'd0, mode}, 0);
    wr(0, 0);
    slow_wait(12);
  endtask

  task automatic t_select;
    logic [31:0] d;
    int n = exp_wait(2);
    wr(1, 2 << 8);
    wr(0, 32'h5);
    rd(3, d); chk("R8 held", d, 0);
    slow_wait(n + 6); rd(3, d); chk("R8 osc0", d, 1);
    chk("R8 clk_sel", {30'd0, clk_sel}, 1);
    wr(0, 32'h1);
    @(negedge clk); chk("R11 fallback", {30'd0, clk_sel}, 0);
    wr(0, 32'h2);
    @(negedge clk); rd(3, d); chk("R9 pll", d, 2);
    wr(0, 32'h3);
    @(negedge clk); rd(3, d); chk("R10 reserved", d, 2);
    wr(0, 32'h0);
    @(negedge clk); chk("R9 slow", {30'd0, clk_sel}, 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    slow_wait(2);
    t_reset();
    t_regmap();
    t_delay(0, "R3 code0");
    t_delay(1, "R3 code1");
    t_delay(3, "R3 code3");
    t_delay(7, "R4 code7");
    t_restart();
    t_select();
    done = 1;
    finish_run();
  end
endmodule